// File: doc/BRIEF.md
# Dual-Slot Shared Buffer Memory

This block is the byte-wide buffer memory of a USB device controller. Two requesters share it: a CPU-side bus bridge (the host port) and the serial interface engine (the engine port). Both use the same storage, which holds the buffer descriptor table and the endpoint data buffers. Any byte that neither of those uses is ordinary working memory for the CPU side. Arbitration takes no wait states. A single-port RAM runs on a clock at twice the bus rate, and each bus cycle splits into two fixed slots. The first slot belongs to the host port and the second to the engine port. Each requester can therefore issue one access in every bus cycle and is never stalled.

Each port has a valid strobe, a write enable, an 8-bit address, write data and registered read data. Read data for both ports comes back with the same fixed latency: a read issued in one bus cycle is seen throughout the next bus cycle. A module-enable input controls the engine port. While the enable is low, the engine port is shut out and the whole memory behaves as plain memory for the host port.

The fast clock's rising edges coincide with the bus clock's rising edges. Reset is released just after a bus-clock edge, so the first fast edge after reset falls in the middle of a bus cycle and serves the host slot.

Top module: `dual_slot_buf_ram`

## Requirements
- R1: The memory stores 256 bytes, addressed by an 8-bit address on each port. A byte written at any address through the host port reads back unchanged through either port.
- R2: Slots alternate on every fast-clock edge. The mid-bus-cycle edge serves the host port and the bus-edge edge serves the engine port, so both ports complete one access in the same bus cycle with no stall.
- R3: A read issued by either port during bus cycle n (valid=1, write enable=0) appears on that port's read data throughout bus cycle n+1.
- R4: A port's read data keeps its last value in any bus cycle where that port issues no read (valid=0, or a write).
- R5: While the module enable is 0, engine-port requests are ignored. Engine writes leave memory unchanged and engine read data holds its value. Host-port accesses are unaffected.
- R6: When both ports write the same address in the same bus cycle, the engine's byte is the one stored.
- R7: In a bus cycle where one port reads an address that the other port writes, the host read returns the byte stored before the cycle, and the engine read returns the byte the host writes.
- R8: During and right after reset, both read data outputs are 0 and the slot sequence starts with the host slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | RAM clock at twice the bus rate, rising edges aligned to bus edges |
| rst_n | input | 1 | Synchronous active-low reset |
| usb_en | input | 1 | Module enable; 0 shuts out the engine port |
| host_valid | input | 1 | Host-port request strobe for this bus cycle |
| host_we | input | 1 | Host-port write enable |
| host_addr | input | 8 | Host-port byte address |
| host_wdata | input | 8 | Host-port write data |
| host_rdata | output | 8 | Host-port read data, one bus cycle after the read |
| eng_valid | input | 1 | Engine-port request strobe for this bus cycle |
| eng_we | input | 1 | Engine-port write enable |
| eng_addr | input | 8 | Engine-port byte address |
| eng_wdata | input | 8 | Engine-port write data |
| eng_rdata | output | 8 | Engine-port read data, one bus cycle after the read |

## Verification
A host access and an engine access always share a bus cycle. The hard case is when both touch the same byte: two writes, or a read on one side with a write on the other. The bench forces this case with directed cycles at one address. It also runs long random traffic confined to sixteen addresses and randomly toggles the module enable. A reference model in the bench applies the host operation first and the engine operation second in every bus cycle. That model sets the expected byte that each port's read data must show in the following bus cycle.

// File: rtl/buf_ram_pkg.sv
// Package: shared types for the dual-slot buffer memory.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package buf_ram_pkg;

    // Which requester the next fast-clock edge serves.
    typedef enum logic {
        SLOT_HOST = 1'b0,
        SLOT_ENG  = 1'b1
    } slot_e;

endpackage

// File: rtl/slot_phase.sv
// slot_phase: toggle flop that names the requester served by the next
// fast-clock edge.
// Assumes: reset is released just after a bus edge, so the first edge
// after reset falls mid bus cycle and belongs to the host.
module slot_phase
    import buf_ram_pkg::*;
(
    input  logic  clk_fast,
    input  logic  rst_n,
    output slot_e slot_o
);

    // Alternate host/engine on every fast edge; reset starts in host slot.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            slot_o <= SLOT_HOST;
        end else begin
            slot_o <= (slot_o == SLOT_HOST) ? SLOT_ENG : SLOT_HOST;
        end
    end

    // R2
    host_then_eng_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (slot_o == SLOT_HOST) |=> (slot_o == SLOT_ENG));

    // R2
    eng_then_host_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (slot_o == SLOT_ENG) |=> (slot_o == SLOT_HOST));

    // R8
    reset_host_slot_chk: assert property (@(posedge clk_fast)
        !rst_n |=> (slot_o == SLOT_HOST));

endmodule

// File: rtl/slot_port_mux.sv
// slot_port_mux: steers the request of the requester owning the current
// slot onto the single RAM port and flags which port is reading.
// Assumes: requests are held stable for a whole bus cycle; eng_allow
// gates every engine access.
module slot_port_mux
    import buf_ram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  slot_e              slot,
    input  logic               eng_allow,
    input  logic               host_valid,
    input  logic               host_we,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               eng_valid,
    input  logic               eng_we,
    input  logic [ADDR_W-1:0]  eng_addr,
    input  logic [DATA_W-1:0]  eng_wdata,
    output logic               ram_we,
    output logic [ADDR_W-1:0]  ram_addr,
    output logic [DATA_W-1:0]  ram_wdata,
    output logic               host_rd,
    output logic               eng_rd
);

    // Select the slot owner's address, data and operation.
    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = host_addr;
        ram_wdata = host_wdata;
        host_rd   = 1'b0;
        eng_rd    = 1'b0;
        if (slot == SLOT_HOST) begin
            ram_we  = host_valid & host_we;
            host_rd = host_valid & ~host_we;
        end else begin
            ram_addr  = eng_addr;
            ram_wdata = eng_wdata;
            ram_we    = eng_allow & eng_valid & eng_we;
            eng_rd    = eng_allow & eng_valid & ~eng_we;
        end
    end

endmodule

// File: rtl/sp_ram.sv
// sp_ram: single-port storage with synchronous write and combinational
// read of the addressed word.
// Assumes: one access per clock edge; contents are not reset.
module sp_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the write word at the selected address.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Present the addressed word for the slot owner to capture.
    assign rdata = mem[addr];

endmodule

// File: rtl/read_return.sv
// read_return: captures read bytes in their slots and releases both
// ports' results together on the bus-aligned edge, giving equal latency.
// Assumes: the engine slot edge coincides with a bus-clock rising edge.
module read_return
    import buf_ram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk_fast,
    input  logic               rst_n,
    input  slot_e              slot,
    input  logic               host_rd,
    input  logic               eng_rd,
    input  logic [DATA_W-1:0]  ram_rdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic [DATA_W-1:0]  eng_rdata
);

    logic [DATA_W-1:0] host_stage;
    logic              host_stage_vld;

    // Hold the host byte from the mid-cycle slot until the bus edge.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            host_stage     <= '0;
            host_stage_vld <= 1'b0;
        end else if (slot == SLOT_HOST) begin
            host_stage     <= ram_rdata;
            host_stage_vld <= host_rd;
        end
    end

    // Update both read outputs on the bus-aligned edge only.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            host_rdata <= '0;
            eng_rdata  <= '0;
        end else if (slot == SLOT_ENG) begin
            if (host_stage_vld) begin
                host_rdata <= host_stage;
            end
            if (eng_rd) begin
                eng_rdata <= ram_rdata;
            end
        end
    end

    // R3
    host_mid_stable_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (slot == SLOT_HOST) |=> ($stable(host_rdata) && $stable(eng_rdata)));

    // R4
    eng_hold_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (slot == SLOT_ENG && !eng_rd) |=> $stable(eng_rdata));

    // R8
    reset_zero_chk: assert property (@(posedge clk_fast)
        !rst_n |=> (host_rdata == '0 && eng_rdata == '0));

endmodule

// File: rtl/dual_slot_buf_ram.sv
// dual_slot_buf_ram: shared byte memory serving a host port and an engine
// port in alternating fast-clock slots, one access each per bus cycle.
// Assumes: clk_fast runs at twice the bus rate with rising edges on bus
// edges; rst_n is released just after a bus edge; requests are held for
// the whole bus cycle.
module dual_slot_buf_ram
    import buf_ram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic               clk_fast,
    input  logic               rst_n,
    input  logic               usb_en,
    input  logic               host_valid,
    input  logic               host_we,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               eng_valid,
    input  logic               eng_we,
    input  logic [ADDR_W-1:0]  eng_addr,
    input  logic [DATA_W-1:0]  eng_wdata,
    output logic [DATA_W-1:0]  eng_rdata
);

    slot_e             slot;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;
    logic              host_rd;
    logic              eng_rd;

    slot_phase u_phase (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .slot_o   (slot)
    );

    slot_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .slot       (slot),
        .eng_allow  (usb_en),
        .host_valid (host_valid),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .eng_valid  (eng_valid),
        .eng_we     (eng_we),
        .eng_addr   (eng_addr),
        .eng_wdata  (eng_wdata),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .host_rd    (host_rd),
        .eng_rd     (eng_rd)
    );

    sp_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk_fast),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    read_return #(.DATA_W(DATA_W)) u_ret (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .slot       (slot),
        .host_rd    (host_rd),
        .eng_rd     (eng_rd),
        .ram_rdata  (ram_rdata),
        .host_rdata (host_rdata),
        .eng_rdata  (eng_rdata)
    );

    // R5
    eng_shut_out_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (slot == SLOT_ENG && !usb_en) |-> (!ram_we && !eng_rd));

    // R2
    host_slot_only_host_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (slot == SLOT_HOST) |-> (!eng_rd && ram_we == (host_valid && host_we)));

endmodule

// File: tb/tb_dual_slot_buf_ram.sv
module tb_dual_slot_buf_ram;

    localparam int FAST_PERIOD = 10;
    localparam int BUS_PERIOD  = 2 * FAST_PERIOD;

    logic       clk_fast = 1'b1;
    logic       clk_bus  = 1'b0;
    logic       rst_n    = 1'b0;
    logic       usb_en   = 1'b0;
    logic       host_valid = 1'b0, host_we = 1'b0;
    logic [7:0] host_addr = '0, host_wdata = '0;
    logic [7:0] host_rdata;
    logic       eng_valid = 1'b0, eng_we = 1'b0;
    logic [7:0] eng_addr = '0, eng_wdata = '0;
    logic [7:0] eng_rdata;

    always #(FAST_PERIOD/2) clk_fast = ~clk_fast;
    always #(FAST_PERIOD)   clk_bus  = ~clk_bus;

    dual_slot_buf_ram dut (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .usb_en     (usb_en),
        .host_valid (host_valid),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eng_valid  (eng_valid),
        .eng_we     (eng_we),
        .eng_addr   (eng_addr),
        .eng_wdata  (eng_wdata),
        .eng_rdata  (eng_rdata)
    );

    int vectors = 0;
    int errors  = 0;
    int bus_cycle = 0;
    bit done = 0;

    logic [7:0] model [256];
    logic [7:0] exp_h = '0, exp_e = '0;

    int         due_q [$];
    logic [7:0] eh_q  [$];
    logic [7:0] ee_q  [$];
    string      tag_q [$];

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %02h expected %02h (bus cycle %0d)",
                     tag, what, act, exp, bus_cycle);
        end
    endtask

    always @(posedge clk_bus) bus_cycle <= bus_cycle + 1;

    // Monitor: pop expected items once their bus cycle is reached.
    always @(posedge clk_bus) begin
        #(FAST_PERIOD/2);
        while (due_q.size() > 0 && due_q[0] <= bus_cycle) begin
            chk(tag_q[0], "host_rdata", host_rdata, eh_q[0]);
            chk(tag_q[0], "eng_rdata",  eng_rdata,  ee_q[0]);
            void'(due_q.pop_front());
            void'(eh_q.pop_front());
            void'(ee_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    // Driver: one bus cycle of stimulus; the model applies host then engine.
    task automatic step(input logic hv, input logic hw, input logic [7:0] ha,
                        input logic [7:0] hd, input logic ev, input logic ew,
                        input logic [7:0] ea, input logic [7:0] ed,
                        input logic en, input string tag);
        @(posedge clk_bus);
        #1;
        host_valid = hv; host_we = hw; host_addr = ha; host_wdata = hd;
        eng_valid  = ev; eng_we  = ew; eng_addr  = ea; eng_wdata  = ed;
        usb_en = en;
        if (hv) begin
            if (hw) model[ha] = hd;
            else    exp_h = model[ha];
        end
        if (ev && en) begin
            if (ew) model[ea] = ed;
            else    exp_e = model[ea];
        end
        due_q.push_back(bus_cycle + 1);
        eh_q.push_back(exp_h);
        ee_q.push_back(exp_e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00, 1, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk_bus);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk_bus);
        #1;
        rst_n = 1'b1;
        #4;
        // R8: outputs zero right after reset
        chk("R8", "host_rdata after reset", host_rdata, 8'h00);
        chk("R8", "eng_rdata after reset",  eng_rdata,  8'h00);

        // R1: fill every byte through the host port
        for (int a = 0; a < 256; a++)
            step(1, 1, a[7:0], a[7:0] ^ 8'h5A, 0, 0, 8'h00, 8'h00, 1, "R1");
        // R1/R2: both ports read back in the same bus cycles
        for (int a = 0; a < 256; a++)
            step(1, 0, a[7:0], 8'h00, 1, 0, 8'(255 - a), 8'h00, 1, "R2");

        // R3: single reads with idle cycles between show one-cycle latency
        step(1, 0, 8'h21, 8'h00, 0, 0, 8'h00, 8'h00, 1, "R3");
        idle("R3");
        step(0, 0, 8'h00, 8'h00, 1, 0, 8'h42, 8'h00, 1, "R3");
        idle("R3");

        // R4: writes and idle cycles leave read data untouched
        step(1, 1, 8'h30, 8'hC3, 1, 1, 8'h31, 8'h3C, 1, "R4");
        step(0, 1, 8'h30, 8'h11, 0, 1, 8'h31, 8'h22, 1, "R4");
        step(1, 0, 8'h30, 8'h00, 1, 0, 8'h31, 8'h00, 1, "R4");

        // R5: engine shut out while disabled, host still works
        step(1, 0, 8'h0A, 8'h00, 1, 1, 8'h0A, 8'hFF, 0, "R5");
        step(1, 1, 8'h0B, 8'h77, 1, 0, 8'h0A, 8'h00, 0, "R5");
        step(1, 0, 8'h0B, 8'h00, 1, 0, 8'h0A, 8'h00, 1, "R5");

        // R6: simultaneous writes to one byte, engine byte stays
        step(1, 1, 8'h50, 8'hAA, 1, 1, 8'h50, 8'h55, 1, "R6");
        step(1, 0, 8'h50, 8'h00, 1, 0, 8'h50, 8'h00, 1, "R6");

        // R7: host read vs engine write, then host write vs engine read
        step(1, 0, 8'h60, 8'h00, 1, 1, 8'h60, 8'h99, 1, "R7");
        step(1, 1, 8'h61, 8'hE7, 1, 0, 8'h61, 8'h00, 1, "R7");
        step(1, 0, 8'h61, 8'h00, 1, 0, 8'h60, 8'h00, 1, "R7");

        // R2: random concurrent traffic on a small address window
        for (int i = 0; i < 2000; i++)
            step($urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0,
                 8'($urandom_range(0, 15)), 8'($urandom_range(0, 255)),
                 $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0,
                 8'($urandom_range(0, 15)), 8'($urandom_range(0, 255)),
                 $urandom_range(0, 7) != 0, "R2");

        repeat (3) idle("R4");
        repeat (3) @(posedge clk_bus);
        #(FAST_PERIOD);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule